// File: doc/BRIEF.md
# Programmable Wait-State Ready Generator

This block produces the internal extend signal that decides whether an external bus access keeps running or ends. Each access is announced by a one-cycle start strobe. On that strobe the block captures a held wait count and a held combine mode. It then runs a down-counter from the captured count to zero. The counter's extend indication is merged with an external extend line according to the captured mode.

Polarity is the same throughout. A 1 on the output, on the external line or on the counter indication means "stretch the access". A 0 means "ready, finish it". The wait count and the mode sit in a small held register that is written through a write strobe. After reset the count is seven and the mode is counter-only, so a slow memory is safe by default. A second instance with its own fields can serve a second bus.

Top module: `wsg_ready_gen`

## Requirements
- R1: After reset the held wait count is 7, the held mode is 01, the counter is 0 and extend_o is 0. A first access started without any configuration write therefore extends for exactly 7 cycles.
- R2: A start_i high at a clock edge loads the held count into the counter. extend_o follows that count from the next cycle on, so a count of N gives N extend cycles in mode 01, and a count of 0 gives none.
- R3: Without a start, the counter drops by one on each clock while it is nonzero. Once it reaches 0 it stays at 0 until the next start.
- R4: The counter's extend indication is 1 exactly while the counter is nonzero.
- R5: In mode 00, extend_o equals ext_extend_i and the counter has no effect.
- R6: In mode 01, extend_o equals the counter's indication and ext_extend_i has no effect.
- R7: In mode 10, the access finishes when either source is ready: extend_o = ext_extend_i AND counter indication.
- R8: In mode 11, the access finishes only when both sources are ready: extend_o = ext_extend_i OR counter indication.
- R9: A start that arrives while the counter is still nonzero reloads the counter from the held count.
- R10: Mode and count are captured only at a start. A configuration write during an access does not change that access. When a write and a start fall in the same cycle, the start uses the values held before the write.
- R11: cfg_we_i high at a clock edge stores cfg_wait_i and cfg_mode_i into the held register. They are kept until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the held count and mode |
| cfg_wait_i | input | 3 | Wait count to hold (0 to 7) |
| cfg_mode_i | input | 2 | Combine mode to hold: 00 external, 01 counter, 10 either finishes, 11 both needed |
| start_i | input | 1 | Access start strobe, one cycle |
| ext_extend_i | input | 1 | External extend line, 1 stretches the access |
| extend_o | output | 1 | Internal extend, 1 stretches the access and 0 finishes it |

## Verification
Two events can land in the same clock edge. The first is a start and a configuration write together: the start must capture the old held fields and the write must only affect the next access. The second is a start while the counter is still running: it must reload the counter rather than let it keep decrementing. The bench provokes both on purpose, and also writes the fields in the middle of an access. A behavioural model captures the fields on a start before it applies the write, and extend_o is compared with that model on every cycle under a pseudo-random external line.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic [1:0] {
    MODE_EXT = 2'b00,  // external line only
    MODE_CNT = 2'b01,  // counter only
    MODE_ANY = 2'b10,  // either source ready finishes
    MODE_ALL = 2'b11   // both sources ready needed
  } wsg_mode_e;
endpackage

// File: rtl/wsg_cfg_reg.sv
module wsg_cfg_reg
  import wsg_pkg::*;
#(
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned RST_CNT  = 7,
  parameter wsg_mode_e   RST_MODE = MODE_CNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  wsg_mode_e        mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output wsg_mode_e        mode_o
);
  localparam logic [CNT_W-1:0] CntRst = CNT_W'(RST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= CntRst;
      mode_o <= RST_MODE;
    end else if (we_i) begin
      cnt_o  <= cnt_i;
      mode_o <= mode_i;
    end
  end

  p_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cnt_o == $past(cnt_i)) && (mode_o == $past(mode_i)));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cnt_o) && $stable(mode_o));
endmodule

// File: rtl/wsg_counter.sv
module wsg_counter
  import wsg_pkg::*;
#(
  parameter int unsigned CNT_W    = 3,
  parameter wsg_mode_e   RST_MODE = MODE_CNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  input  wsg_mode_e        mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output wsg_mode_e        mode_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] One = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  wsg_mode_e        mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= RST_MODE;
    end else if (start_i) begin
      cnt_q  <= load_i;
      mode_q <= mode_i;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - One;
    end
  end

  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign busy_o = |cnt_q;

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_q == $past(load_i));

  p_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - One);

  p_stay_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q == '0) |=> cnt_q == '0);

  p_mode_capture_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(mode_q));
endmodule

// File: rtl/wsg_combine.sv
module wsg_combine
  import wsg_pkg::*;
(
  input  wsg_mode_e mode_i,
  input  logic      cnt_ext_i,
  input  logic      ext_i,
  output logic      extend_o
);
  // 1 = stretch; "either ready" is an AND of the stretch requests
  always_comb begin
    unique case (mode_i)
      MODE_EXT: extend_o = ext_i;
      MODE_CNT: extend_o = cnt_ext_i;
      MODE_ANY: extend_o = ext_i & cnt_ext_i;
      MODE_ALL: extend_o = ext_i | cnt_ext_i;
      default:  extend_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wsg_ready_gen.sv
module wsg_ready_gen
  import wsg_pkg::*;
#(
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned RST_CNT  = 7,
  parameter logic [1:0]  RST_MODE = 2'b01
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] cfg_wait_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic             start_i,
  input  logic             ext_extend_i,
  output logic             extend_o
);
  localparam wsg_mode_e ModeRst = wsg_mode_e'(RST_MODE);

  logic [CNT_W-1:0] held_cnt;
  wsg_mode_e        held_mode;
  logic [CNT_W-1:0] run_cnt;
  wsg_mode_e        run_mode;
  logic             cnt_busy;

  wsg_cfg_reg #(
    .CNT_W   (CNT_W),
    .RST_CNT (RST_CNT),
    .RST_MODE(ModeRst)
  ) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .cnt_i (cfg_wait_i),
    .mode_i(wsg_mode_e'(cfg_mode_i)),
    .cnt_o (held_cnt),
    .mode_o(held_mode)
  );

  wsg_counter #(
    .CNT_W   (CNT_W),
    .RST_MODE(ModeRst)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_i (held_cnt),
    .mode_i (held_mode),
    .cnt_o  (run_cnt),
    .mode_o (run_mode),
    .busy_o (cnt_busy)
  );

  wsg_combine u_comb (
    .mode_i   (run_mode),
    .cnt_ext_i(cnt_busy),
    .ext_i    (ext_extend_i),
    .extend_o (extend_o)
  );

  // counter-only access, once finished, stays finished until a new start
  p_cnt_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_mode == MODE_CNT && !start_i && !extend_o) |=> !extend_o);

  // start captures fields held before a same-cycle write
  p_collide_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cfg_we_i) |=> run_cnt == $past(held_cnt));

  // both-needed mode: external stretch always stretches
  p_all_ext_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_mode == MODE_ALL && ext_extend_i) |-> extend_o);

  // either-finishes mode: finished counter always finishes
  p_any_cnt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_mode == MODE_ANY && run_cnt == '0) |-> !extend_o);
endmodule

// File: tb/tb_wsg_ready_gen.sv
module tb_wsg_ready_gen;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned MAX_CYCLES = 200000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_wait_i = '0;
  logic [1:0] cfg_mode_i = '0;
  logic       start_i = 1'b0;
  logic       ext_extend_i = 1'b0;
  logic       extend_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // behavioural reference
  int m_hcnt, m_hmode, m_cnt, m_mode;
  int lfsr = 32'h1ACE;

  wsg_ready_gen dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wait_i  (cfg_wait_i),
    .cfg_mode_i  (cfg_mode_i),
    .start_i     (start_i),
    .ext_extend_i(ext_extend_i),
    .extend_o    (extend_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (start_i) begin
        m_cnt  = m_hcnt;
        m_mode = m_hmode;
      end else if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
      end
      if (cfg_we_i) begin
        m_hcnt  = int'(cfg_wait_i);
        m_hmode = int'(cfg_mode_i);
      end
    end
  end

  function automatic logic model_ext(input logic ext);
    logic c;
    c = (m_cnt != 0);
    case (m_mode)
      0:       return ext;
      1:       return c;
      2:       return ext & c;
      default: return ext | c;
    endcase
  endfunction

  function automatic string mode_req();
    case (m_mode)
      0:       return "R5";
      1:       return "R6";
      2:       return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: extend_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive on falling edge, compare, then let the rising edge pass
  task automatic cyc(input string tag, input logic st, input logic we,
                     input int wcnt, input int mode, input int ext_sel);
    @(negedge clk_i);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    start_i    = st;
    cfg_we_i   = we;
    cfg_wait_i = 3'(wcnt);
    cfg_mode_i = 2'(mode);
    ext_extend_i = (ext_sel == 2) ? lfsr[3] : ext_sel[0];
    #1;
    check({tag, "/", mode_req()}, extend_o, model_ext(ext_extend_i));
  endtask

  task automatic idle(input string tag, input int n, input int ext_sel);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 1'b0, 0, 0, ext_sel);
  endtask

  task automatic access(input string tag, input int wcnt, input int mode,
                        input int ext_sel, input int tail);
    cyc(tag, 1'b0, 1'b1, wcnt, mode, ext_sel);  // R11 write
    cyc(tag, 1'b1, 1'b0, 0, 0, ext_sel);
    idle(tag, wcnt + tail, ext_sel);
  endtask

  initial begin
    m_hcnt = 7; m_hmode = 1; m_cnt = 0; m_mode = 1;
    repeat (3) @(negedge clk_i);
    #1;
    check("R1 reset", extend_o, 1'b0);
    rst_ni = 1'b1;

    // R1 R2 R4: default seven waits, external line ignored
    cyc("R1_default", 1'b1, 1'b0, 0, 0, 1);
    idle("R1_R2_R3_R4", 10, 2);

    // mode coverage with random external line
    for (int md = 0; md < 4; md++)
      for (int w = 0; w < 8; w++)
        access("R5_R6_R7_R8", w, md, 2, 3);

    // R2: zero count finishes at once in counter mode
    access("R2_zero", 0, 1, 1, 2);

    // R9: restart while counter still nonzero
    cyc("R9", 1'b0, 1'b1, 5, 1, 0);
    cyc("R9", 1'b1, 1'b0, 0, 0, 0);
    idle("R9", 2, 0);
    cyc("R9_reload", 1'b1, 1'b0, 0, 0, 0);
    idle("R9", 7, 0);
    cyc("R9_mode3", 1'b0, 1'b1, 6, 3, 0);
    cyc("R9", 1'b1, 1'b0, 0, 0, 0);
    cyc("R9", 1'b0, 1'b0, 0, 0, 0);
    cyc("R9_reload", 1'b1, 1'b0, 0, 0, 2);
    idle("R9", 8, 2);

    // R10: write during access has no effect on it
    cyc("R10", 1'b0, 1'b1, 6, 1, 1);
    cyc("R10", 1'b1, 1'b0, 0, 0, 1);
    cyc("R10_midwrite", 1'b0, 1'b1, 1, 0, 0);
    idle("R10", 7, 0);
    // R10: write and start in the same cycle
    cyc("R10", 1'b0, 1'b1, 2, 1, 0);
    cyc("R10_collide", 1'b1, 1'b1, 7, 0, 0);
    idle("R10", 4, 1);
    cyc("R10_R11_next", 1'b1, 1'b0, 0, 0, 2);
    idle("R11", 9, 2);

    // R1: reset in the middle of an access
    cyc("R1", 1'b0, 1'b1, 3, 3, 0);
    cyc("R1", 1'b1, 1'b0, 0, 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b0; start_i = 1'b0; cfg_we_i = 1'b0; ext_extend_i = 1'b1;
    m_hcnt = 7; m_hmode = 1; m_cnt = 0; m_mode = 1;
    #1;
    check("R1 reset_mid", extend_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc("R1_after", 1'b1, 1'b0, 0, 0, 1);
    idle("R1_after", 9, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule